// File: doc/BRIEF.md
# Memory tag check unit

This block decides, for one memory access in a tagged-memory system, whether the access may proceed. The caller presents the 64-bit pointer, a small descriptor word, the allocation tag read from tag storage, the privilege level of the access, whether its translation regime has two address ranges, and the system-control word of that level. The block first decides whether the access is checked at all. If it is checked, it compares the 4-bit logical tag in pointer bits 59:56 with the stored tag.

On a mismatch, the 2-bit fault mode taken from the control word chooses the reaction. Mode 1 raises a synchronous abort with a packed syndrome and the fault address. Mode 2 sets a sticky bit in a per-level fault status register. Modes 0 and 3 have no effect. The request side uses a valid/ready handshake. The result appears one cycle after the request is accepted and is held until it is taken. The sticky flags are cleared only by reset or by a write through the status write port.

Descriptor layout: bits 1:0 are the two top-byte-check enables and bits 3:2 are the two tag-match bypass enables. In both pairs, pointer bit 55 selects the bit. Bits 7:4 hold a memory-context index. Bit 8 is the store flag and bits 13:9 are the element size.

Top module: `tag_check_unit`

## Requirements
- R1: After reset, out_valid, abort_req and every bit of sts_flags are 0, and in_ready is 1.
- R2: If descriptor bit (0 + pointer bit 55) is 0, the access is unchecked. It passes (out_pass=1), raises no abort and sets no flag, whatever the tags are.
- R3: If the access is checked, descriptor bit (2 + pointer bit 55) is 1, and pointer bits 59:55 are all zeros or all ones, the access passes without comparing tags.
- R4: Otherwise the access passes when in_atag equals pointer bits 59:56 or when in_atag_present is 0. It fails when a present stored tag differs.
- R5: The fault mode is in_sctlr[39:38] when in_level is 0 and in_sctlr[41:40] otherwise.
- R6: A failure in mode 1 raises abort_req with the result. abort_addr then equals the full pointer. abort_syndrome is 32'h96000011 when in_level is nonzero and 32'h92000011 when in_level is 0: fault status 0x11 in bits 5:0, instruction-length bit 25, and class 0x24 or 0x25 in bits 31:26. Bits 10:6 are zero.
- R7: A failure in mode 2 raises no abort. It sets flag bit 2*level+idx of sts_flags, where idx is pointer bit 55 if in_two_ranges is 1 and 0 otherwise.
- R8: A failure in mode 0 or mode 3 raises no abort and changes no flag, but still reports out_pass=0.
- R9: out_ptr returns the pointer unchanged, and out_store returns descriptor bit 8.
- R10: A request accepted at an edge (in_valid and in_ready) gives out_valid on that edge. While out_valid=1 and out_ready=0, the result stays stable and in_ready is 0.
- R11: Flags are sticky. Only a write (sts_wr_en, sts_wr_level, sts_wr_data) replaces a level's two bits. If a write and a mode-2 set land on the same edge, the result is the written value with the set bit ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_ptr | input | 64 | Access pointer |
| in_desc | input | 14 | Check descriptor |
| in_atag | input | 4 | Stored allocation tag |
| in_atag_present | input | 1 | Stored tag exists for this address |
| in_level | input | 2 | Privilege level of the access |
| in_two_ranges | input | 1 | Regime has two address ranges |
| in_sctlr | input | 64 | System-control word of that level |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken |
| out_pass | output | 1 | Access allowed by the tag check |
| out_ptr | output | 64 | Pointer returned to the caller |
| out_store | output | 1 | Access is a store |
| abort_req | output | 1 | Synchronous tag-fault abort |
| abort_syndrome | output | 32 | Syndrome word of the abort |
| abort_addr | output | 64 | Fault address of the abort |
| sts_wr_en | input | 1 | Fault status write strobe |
| sts_wr_level | input | 2 | Level whose status is written |
| sts_wr_data | input | 2 | New status bits |
| sts_flags | output | 8 | Sticky flags, two per level |

## Verification
Two functions can land on the same edge: a mode-2 failure that sets a sticky bit, and a software write to that level's status bits. The bench provokes this by holding a write of zero on the status port while it presents a failing mode-2 request, so that both are taken on one edge. It then judges the flags on the next cycle against a model in which the set bit survives the write. A second case writes a value that keeps a different bit, and checks that both bits remain.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  localparam int PTR_W  = 64;
  localparam int DESC_W = 14;
  localparam int TAG_W  = 4;
  localparam int SYN_W  = 32;

  typedef enum logic [1:0] {
    FM_NONE  = 2'd0,
    FM_SYNC  = 2'd1,
    FM_ASYNC = 2'd2,
    FM_RSVD  = 2'd3
  } fault_mode_e;

  function automatic logic [TAG_W-1:0] ptr_tag(input logic [PTR_W-1:0] p);
    return p[59:56];
  endfunction

  // A pattern of 00000 or 11111 in bits 59:55 folds to a zero 4-bit sum.
  function automatic logic edge_pattern(input logic [PTR_W-1:0] p);
    logic [TAG_W-1:0] s;
    s = p[59:56] + {3'b000, p[55]};
    return (s == '0);
  endfunction

  function automatic fault_mode_e pick_mode(input logic [PTR_W-1:0] ctl, input logic lvl0);
    return lvl0 ? fault_mode_e'(ctl[39:38]) : fault_mode_e'(ctl[41:40]);
  endfunction

  function automatic logic [SYN_W-1:0] tag_syndrome(input logic same_lvl);
    logic [5:0] cls;
    cls = 6'h24 | {5'b0, same_lvl};
    return {cls, 1'b1, 14'b0, 5'b00000, 6'h11};
  endfunction

endpackage

// File: rtl/tcu_decide.sv
module tcu_decide
  import tcu_pkg::*;
(
  input  logic [PTR_W-1:0]  ptr,
  input  logic [DESC_W-1:0] desc,
  input  logic [TAG_W-1:0]  atag,
  input  logic              atag_present,
  input  logic              lvl_zero,
  input  logic [PTR_W-1:0]  sctlr,
  output logic              checked,
  output logic              fail,
  output logic              do_abort,
  output logic              do_async
);
  logic        b55;
  logic        tbi_on;
  logic        bypass;
  fault_mode_e mode;

  assign b55    = ptr[55];
  assign tbi_on = desc[{1'b0, b55}];
  assign bypass = desc[2 + {1'b0, b55}] && edge_pattern(ptr);

  assign checked = tbi_on && !bypass;
  assign fail    = checked && atag_present && (ptr_tag(ptr) != atag);
  assign mode    = pick_mode(sctlr, lvl_zero);

  always_comb begin
    do_abort = 1'b0;
    do_async = 1'b0;
    if (fail) begin
      unique case (mode)
        FM_SYNC:  do_abort = 1'b1;
        FM_ASYNC: do_async = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/tcu_fault_status.sv
module tcu_fault_status #(
  parameter int NUM_LVL = 4,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [LVL_W-1:0]   set_level,
  input  logic               set_idx,
  input  logic               wr_en,
  input  logic [LVL_W-1:0]   wr_level,
  input  logic [1:0]         wr_data,
  output logic [2*NUM_LVL-1:0] flags
);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic [1:0] q;
    logic [1:0] base;
    logic [1:0] add;
    assign base = (wr_en && wr_level == LVL_W'(g)) ? wr_data : q;
    assign add  = (set_en && set_level == LVL_W'(g)) ? (set_idx ? 2'b10 : 2'b01) : 2'b00;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 2'b00;
      else        q <= base | add;
    end
    assign flags[2*g +: 2] = q;
  end
endmodule

// File: rtl/tcu_result_stage.sv
module tcu_result_stage
  import tcu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             take,
  input  logic             pass_d,
  input  logic             abort_d,
  input  logic             lvl_zero,
  input  logic             store_d,
  input  logic [PTR_W-1:0] ptr_d,
  output logic             valid_q,
  output logic             pass_q,
  output logic             abort_q,
  output logic             store_q,
  output logic [SYN_W-1:0] syn_q,
  output logic [PTR_W-1:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
      abort_q <= 1'b0;
      store_q <= 1'b0;
      syn_q   <= '0;
      ptr_q   <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      pass_q  <= pass_d;
      abort_q <= abort_d;
      store_q <= store_d;
      syn_q   <= abort_d ? tag_syndrome(!lvl_zero) : '0;
      ptr_q   <= ptr_d;
    end else if (take) begin
      valid_q <= 1'b0;
      abort_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tag_check_unit.sv
module tag_check_unit
  import tcu_pkg::*;
#(
  parameter int NUM_LVL = 4,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [63:0]          in_ptr,
  input  logic [13:0]          in_desc,
  input  logic [3:0]           in_atag,
  input  logic                 in_atag_present,
  input  logic [LVL_W-1:0]     in_level,
  input  logic                 in_two_ranges,
  input  logic [63:0]          in_sctlr,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_pass,
  output logic [63:0]          out_ptr,
  output logic                 out_store,
  output logic                 abort_req,
  output logic [31:0]          abort_syndrome,
  output logic [63:0]          abort_addr,
  input  logic                 sts_wr_en,
  input  logic [LVL_W-1:0]     sts_wr_level,
  input  logic [1:0]           sts_wr_data,
  output logic [2*NUM_LVL-1:0] sts_flags
);
  logic accept;
  logic take;
  logic lvl_zero;
  logic checked;
  logic fail;
  logic do_abort;
  logic do_async;
  logic async_set;
  logic unused_desc_bits;

  assign lvl_zero         = (in_level == '0);
  assign take             = out_valid && out_ready;
  assign in_ready         = !out_valid || out_ready;
  assign accept           = in_valid && in_ready;
  assign async_set        = accept && do_async;
  assign unused_desc_bits = ^{in_desc[7:4], in_desc[13:9], checked};

  tcu_decide i_decide (
    .ptr          (in_ptr),
    .desc         (in_desc),
    .atag         (in_atag),
    .atag_present (in_atag_present),
    .lvl_zero     (lvl_zero),
    .sctlr        (in_sctlr),
    .checked      (checked),
    .fail         (fail),
    .do_abort     (do_abort),
    .do_async     (do_async)
  );

  tcu_result_stage i_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .take     (take),
    .pass_d   (!fail),
    .abort_d  (do_abort),
    .lvl_zero (lvl_zero),
    .store_d  (in_desc[8]),
    .ptr_d    (in_ptr),
    .valid_q  (out_valid),
    .pass_q   (out_pass),
    .abort_q  (abort_req),
    .store_q  (out_store),
    .syn_q    (abort_syndrome),
    .ptr_q    (out_ptr)
  );

  assign abort_addr = abort_req ? out_ptr : '0;

  tcu_fault_status #(.NUM_LVL(NUM_LVL)) i_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (async_set),
    .set_level (in_level),
    .set_idx   (in_two_ranges & in_ptr[55]),
    .wr_en     (sts_wr_en),
    .wr_level  (sts_wr_level),
    .wr_data   (sts_wr_data),
    .flags     (sts_flags)
  );
endmodule

// File: rtl/tcu_checker.sv
module tcu_checker #(
  parameter int NUM_LVL = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 out_pass,
  input logic [63:0]          out_ptr,
  input logic                 abort_req,
  input logic [31:0]          abort_syndrome,
  input logic [63:0]          abort_addr,
  input logic                 sts_wr_en,
  input logic                 async_set,
  input logic [2*NUM_LVL-1:0] sts_flags
);
  // R6: an abort is only ever reported with a failing, valid result
  a_r6_abort_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> (out_valid && !out_pass));

  // R6: fault status code and fault address
  a_r6_syndrome_fields: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> (abort_syndrome[5:0] == 6'h11 && abort_syndrome[10:6] == 5'b0
                   && abort_addr == out_ptr));

  // R10: result held while not taken
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pass) && $stable(out_ptr)));

  // R10: no new request while a result waits
  a_r10_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R11: without a write, no flag ever clears
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr_en |=> ((sts_flags & $past(sts_flags)) == $past(sts_flags)));

  // R7: a mode-2 set leaves at least one flag raised
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    async_set |=> (sts_flags != '0));
endmodule

bind tag_check_unit tcu_checker #(.NUM_LVL(NUM_LVL)) i_tcu_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_ready       (in_ready),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_pass       (out_pass),
  .out_ptr        (out_ptr),
  .abort_req      (abort_req),
  .abort_syndrome (abort_syndrome),
  .abort_addr     (abort_addr),
  .sts_wr_en      (sts_wr_en),
  .async_set      (async_set),
  .sts_flags      (sts_flags)
);

// File: tb/test_tag_check_unit.sv
`timescale 1ns/1ps
module test_tag_check_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_ptr = '0;
  logic [13:0] in_desc = '0;
  logic [3:0]  in_atag = '0;
  logic        in_atag_present = 1'b0;
  logic [1:0]  in_level = '0;
  logic        in_two_ranges = 1'b0;
  logic [63:0] in_sctlr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_pass;
  logic [63:0] out_ptr;
  logic        out_store;
  logic        abort_req;
  logic [31:0] abort_syndrome;
  logic [63:0] abort_addr;
  logic        sts_wr_en = 1'b0;
  logic [1:0]  sts_wr_level = '0;
  logic [1:0]  sts_wr_data = '0;
  logic [7:0]  sts_flags;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        pass;
    logic        abort;
    logic [31:0] syn;
    logic [63:0] ptr;
    logic        store;
    string       req;
  } exp_t;

  exp_t       sb[$];
  logic [7:0] exp_flags = '0;

  always #10 clk = ~clk;

  tag_check_unit i_tag_check_unit (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected result built from the requirements
  task automatic send(input logic [63:0] p, input logic [13:0] d, input logic [3:0] at,
                      input logic pres, input logic [1:0] lvl, input logic two,
                      input logic [1:0] mode, input string req);
    exp_t e;
    logic top;
    logic chk;
    logic fl;
    top = (p[59:55] == 5'b00000) || (p[59:55] == 5'b11111);
    chk = (p[55] ? d[1] : d[0]) && !((p[55] ? d[3] : d[2]) && top);
    fl  = chk && pres && (at != p[59:56]);
    e.pass  = !fl;
    e.abort = fl && (mode == 2'd1);
    e.syn   = (lvl != 0) ? 32'h9600_0011 : 32'h9200_0011;
    e.ptr   = p;
    e.store = d[8];
    e.req   = req;
    @(negedge clk);
    in_ptr = p; in_desc = d; in_atag = at; in_atag_present = pres;
    in_level = lvl; in_two_ranges = two;
    in_sctlr = '0;
    if (lvl == 0) in_sctlr[39:38] = mode; else in_sctlr[41:40] = mode;
    in_sctlr[63:60] = 4'hA;
    if (lvl == 0) in_sctlr[41:40] = ~mode; else in_sctlr[39:38] = ~mode;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    if (sts_wr_en) exp_flags[2*sts_wr_level +: 2] = sts_wr_data;
    if (fl && mode == 2'd2) exp_flags[2*lvl + ((two && p[55]) ? 1 : 0)] = 1'b1;
    sb.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
    sts_wr_en = 1'b0;
  endtask

  task automatic check_flags(input string req);
    @(negedge clk);
    check(sts_flags == exp_flags, req, {56'b0, sts_flags}, {56'b0, exp_flags});
  endtask

  // Monitor: compare each taken result with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10 unexpected result", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_pass == e.pass, {e.req, " pass"}, {63'b0, out_pass}, {63'b0, e.pass});
        check(abort_req == e.abort, {e.req, " abort"}, {63'b0, abort_req}, {63'b0, e.abort});
        check(out_ptr == e.ptr, {e.req, " R9 ptr"}, out_ptr, e.ptr);
        check(out_store == e.store, {e.req, " R9 store"}, {63'b0, out_store}, {63'b0, e.store});
        if (e.abort) begin
          check(abort_syndrome == e.syn, {e.req, " R6 syndrome"}, {32'b0, abort_syndrome}, {32'b0, e.syn});
          check(abort_addr == e.ptr, {e.req, " R6 addr"}, abort_addr, e.ptr);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [63:0] mkptr(input logic [3:0] tag, input logic b55);
    logic [63:0] p;
    p = 64'h0000_1234_5678_9AB0;
    p[59:56] = tag;
    p[55] = b55;
    return p;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(out_valid == 0 && abort_req == 0 && sts_flags == 0 && in_ready == 1,
          "R1 reset", {60'b0, out_valid, abort_req, |sts_flags, in_ready}, 64'h1);
    rst_n = 1'b1;

    // R2 unchecked: TBI bit selected by bit 55 is 0
    send(mkptr(4'h3, 1'b0), 14'b00_0000_0000_0010, 4'h7, 1, 2'd1, 0, 2'd1, "R2 tbi0 off");
    send(mkptr(4'h3, 1'b1), 14'b00_0000_0000_0001, 4'h7, 1, 2'd1, 0, 2'd1, "R2 tbi1 off");
    // R4 compare pass and fail, tag absent
    send(mkptr(4'h5, 1'b0), 14'h0103, 4'h5, 1, 2'd1, 0, 2'd1, "R4 match");
    send(mkptr(4'h5, 1'b0), 14'h0003, 4'h6, 0, 2'd1, 0, 2'd1, "R4 absent");
    // R6 sync abort at level 1 and at level 0
    send(mkptr(4'h5, 1'b1), 14'h0103, 4'h6, 1, 2'd1, 0, 2'd1, "R6 abort lvl1");
    send(mkptr(4'h9, 1'b0), 14'h0003, 4'h2, 1, 2'd0, 0, 2'd1, "R6 R5 abort lvl0");
    // R3 bypass with pattern zero and pattern ones
    send(mkptr(4'h0, 1'b0), 14'h0007, 4'hF, 1, 2'd1, 0, 2'd1, "R3 bypass zeros");
    send(mkptr(4'hF, 1'b1), 14'h000B, 4'h1, 1, 2'd1, 0, 2'd1, "R3 bypass ones");
    // R3 bit 55 breaks the pattern: checked
    send(mkptr(4'h0, 1'b1), 14'h000F, 4'h1, 1, 2'd1, 0, 2'd1, "R3 no bypass");
    check_flags("R2 R3 no flags");
    // R7 async: two ranges, bit55=1 -> bit 1 of level 2
    send(mkptr(4'h4, 1'b1), 14'h0003, 4'h1, 1, 2'd2, 1, 2'd2, "R7 async hi");
    check_flags("R7 flag hi");
    // R7 one range -> bit 0 of level 0
    send(mkptr(4'h4, 1'b1), 14'h0003, 4'h1, 1, 2'd0, 0, 2'd2, "R7 R5 async lvl0");
    check_flags("R7 flag lvl0");
    // R8 modes 0 and 3: fail reported, no side effects
    send(mkptr(4'h4, 1'b0), 14'h0003, 4'h1, 1, 2'd3, 0, 2'd3, "R8 mode3");
    send(mkptr(4'h4, 1'b0), 14'h0003, 4'h1, 1, 2'd3, 0, 2'd0, "R8 mode0");
    check_flags("R8 no flag");
    // R5: mode bits of the other level ignored (mode 2 in lvl0 field, level 3 uses mode 1)
    send(mkptr(4'h8, 1'b0), 14'h0003, 4'h1, 1, 2'd3, 0, 2'd1, "R5 field select");
    check_flags("R5 no flag");

    // R11 write and set on the same edge: set survives
    sts_wr_en = 1'b1; sts_wr_level = 2'd1; sts_wr_data = 2'b00;
    send(mkptr(4'h4, 1'b0), 14'h0003, 4'h1, 1, 2'd1, 0, 2'd2, "R11 collide");
    check_flags("R11 write+set");
    sts_wr_en = 1'b1; sts_wr_level = 2'd2; sts_wr_data = 2'b01;
    send(mkptr(4'h4, 1'b1), 14'h0003, 4'h1, 1, 2'd2, 1, 2'd2, "R11 collide keep");
    check_flags("R11 write keep+set");
    // R11 plain write clears
    @(negedge clk);
    sts_wr_en = 1'b1; sts_wr_level = 2'd0; sts_wr_data = 2'b00;
    exp_flags[1:0] = 2'b00;
    @(negedge clk);
    sts_wr_en = 1'b0;
    check(sts_flags == exp_flags, "R11 clear", {56'b0, sts_flags}, {56'b0, exp_flags});

    // R10 backpressure and hold
    out_ready = 1'b0;
    send(mkptr(4'h2, 1'b0), 14'h0003, 4'h3, 1, 2'd1, 0, 2'd1, "R10 held");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid && !in_ready && abort_req, "R10 hold", {61'b0, out_valid, in_ready, abort_req}, 64'h5);
    end
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!out_valid && sb.size() == 0, "R10 drained", {63'b0, out_valid}, 64'd0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule